// File: doc/BRIEF.md
# Power Mode and Core Clock Divider Controller

This block holds one byte-wide control register that decides which parts of a small system stay powered: the processor core, the peripheral group, the PLL, the external crystal circuit and a precision low-frequency reference input. Software writes the register through a simple write strobe and reads it back at any time. The block filters each write so that units are never shut down in an order the system cannot survive. A wake-up event input forcibly restores power to the core, the peripherals and the PLL.

The same register carries a 3-bit divider code. The block turns the fast base clock into a one-cycle clock-enable strobe for the core, issued once every 2^code base cycles. When software clears the core enable, the core receives one more strobe before its enable output drops and the strobe stops. After a wake-up event the strobe starts again from a fresh count.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After a synchronous reset the register reads 0x79 (precision input off, crystal, PLL, peripherals and core on, divider code 001), `core_en` is 1 and `core_clk_en` is 0.
- R2: Register layout: bit 7 precision input enable (`prec_en`), bit 6 crystal enable (`xtal_en`), bit 5 PLL enable (`pll_en`), bit 4 peripheral enable (`periph_en`), bit 3 core enable, bits 2:0 divider code; 1 means powered. A write appears on `rd_data` and the enable outputs on the cycle after `wr_en`.
- R3: A write with bit 4 = 0 and bit 3 = 1 leaves bit 4 at its previous value.
- R4: A write with bit 5 = 0 while bit 3 or bit 4 of the same write is 1 leaves bit 5 at its previous value.
- R5: In a write that breaks R3 or R4, every other field (bits 7, 6, 3 and 2:0) is still taken from the write.
- R6: When `wake_evt` is 1, bits 5, 4 and 3 are 1 on the next cycle, even if a write in the same cycle clears them; the other fields of that write still apply.
- R7: While the core runs with a steady divider code N, `core_clk_en` is a single-cycle pulse repeating every 2^N base cycles; code 000 holds it high every cycle.
- R8: When the divider code changes, the count restarts: `core_clk_en` is 0 on the cycle after the new code appears, and the first new pulse comes 2^N cycles after that.
- R9: After bit 3 is cleared, `core_en` stays 1 until one more `core_clk_en` pulse has been issued and falls on the cycle after that pulse.
- R10: While `core_en` is 0, `core_clk_en` stays 0; once bit 3 is set again (by write or wake-up) `core_en` returns on the next cycle and counting restarts from zero.
- R11: `rd_data` bits above 7 always read 0 and write data above bit 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | BUS_W | Write data, low byte used |
| wake_evt | input | 1 | Wake-up event, one cycle per event |
| rd_data | output | BUS_W | Register readback, upper bits zero |
| core_en | output | 1 | Core power enable, delayed on shutdown |
| periph_en | output | 1 | Peripheral group enable |
| pll_en | output | 1 | PLL enable |
| xtal_en | output | 1 | External crystal enable |
| prec_en | output | 1 | Precision low-frequency input enable |
| core_clk_en | output | 1 | Core clock-enable strobe |

## Verification
The properties assume inputs are sampled only at the rising edge and that reset is held from time zero until at least one edge has passed, so every `$past` term refers to a cycle after reset. They also take `wr_data` and `wake_evt` as arbitrary, including illegal shutdown orders and wake-ups that collide with writes, so the stimulus drives exactly those collisions on purpose. Directed sequences walk all eight divider codes, change the code mid-count and clear the core at different phases of the count, then a long stretch of random writes with rare wake-ups covers the remaining orderings.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int REG_W = 8;
  localparam int CD_W  = 3;

  typedef struct packed {
    logic            prec;
    logic            xtal;
    logic            pll;
    logic            periph;
    logic            core;
    logic [CD_W-1:0] cd;
  } pwr_reg_t;

  localparam pwr_reg_t PWR_RST = 8'h79;

  // Apply the shutdown ordering rules to a requested value.
  function automatic pwr_reg_t filter_write(pwr_reg_t cur, pwr_reg_t req);
    pwr_reg_t res;
    res = req;
    if (!req.periph && req.core)
      res.periph = cur.periph;
    if (!req.pll && (req.core || req.periph))
      res.pll = cur.pll;
    return res;
  endfunction
endpackage

// File: rtl/pcc_reg_file.sv
module pcc_reg_file
  import pcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_byte,
  input  logic             wake_evt,
  output pwr_reg_t         reg_q
);
  pwr_reg_t nxt;

  always_comb begin
    nxt = reg_q;
    if (wr_en)
      nxt = filter_write(reg_q, pwr_reg_t'(wr_byte));
    if (wake_evt) begin
      nxt.core   = 1'b1;
      nxt.periph = 1'b1;
      nxt.pll    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_q <= PWR_RST;
    else     reg_q <= nxt;
  end
endmodule

// File: rtl/pcc_core_gate.sv
module pcc_core_gate (
  input  logic clk,
  input  logic rst,
  input  logic core_bit,
  input  logic tick,
  output logic run,
  output logic run_nxt
);
  // Core keeps running until one more tick after its bit clears.
  assign run_nxt = core_bit | (run & ~tick);

  always_ff @(posedge clk) begin
    if (rst) run <= 1'b1;
    else     run <= run_nxt;
  end
endmodule

// File: rtl/pcc_clk_div.sv
module pcc_clk_div #(
  parameter int CD_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [CD_W-1:0] cd,
  input  logic [CD_W-1:0] cd_rst,
  output logic            tick
);
  localparam int CNT_W = (1 << CD_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CD_W-1:0]  cd_seen;

  // 2^cd - 1, wraps correctly for the top code
  assign lim = (CNT_W'(1) << cd) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      tick    <= 1'b0;
      cd_seen <= cd_rst;
    end else if (!run || cd != cd_seen) begin
      cnt     <= '0;
      tick    <= 1'b0;
      cd_seen <= cd;
    end else if (cnt == lim) begin
      cnt     <= '0;
      tick    <= 1'b1;
    end else begin
      cnt     <= cnt + CNT_W'(1);
      tick    <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             wake_evt,
  output logic [BUS_W-1:0] rd_data,
  output logic             core_en,
  output logic             periph_en,
  output logic             pll_en,
  output logic             xtal_en,
  output logic             prec_en,
  output logic             core_clk_en
);
  pwr_reg_t reg_q;
  logic     run_nxt;
  logic     unused_hi;

  assign unused_hi = ^wr_data[BUS_W-1:REG_W];

  pcc_reg_file u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_byte  (wr_data[REG_W-1:0]),
    .wake_evt (wake_evt),
    .reg_q    (reg_q)
  );

  pcc_core_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .core_bit (reg_q.core),
    .tick     (core_clk_en),
    .run      (core_en),
    .run_nxt  (run_nxt)
  );

  pcc_clk_div #(.CD_W(CD_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run    (run_nxt),
    .cd     (reg_q.cd),
    .cd_rst (PWR_RST.cd),
    .tick   (core_clk_en)
  );

  assign rd_data   = BUS_W'(reg_q);
  assign periph_en = reg_q.periph;
  assign pll_en    = reg_q.pll;
  assign xtal_en   = reg_q.xtal;
  assign prec_en   = reg_q.prec;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [BUS_W-1:0] wr_data,
  input logic             wake_evt,
  input logic [BUS_W-1:0] rd_data,
  input logic             core_en,
  input logic             core_clk_en
);
  assert_periph_order_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wake_evt && wr_data[3] && !wr_data[4]) |=> rd_data[4] == $past(rd_data[4]));

  assert_pll_order_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wake_evt && !wr_data[5] && (wr_data[3] || wr_data[4])) |=> rd_data[5] == $past(rd_data[5]));

  assert_fields_apply_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[7:6] == $past(wr_data[7:6])) && (rd_data[2:0] == $past(wr_data[2:0])));

  assert_wake_restore_R6: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> rd_data[5:3] == 3'b111);

  assert_cd_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_data[2:0] != $past(rd_data[2:0])) |=> !core_clk_en);

  assert_core_drop_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(core_en) |-> ($past(core_clk_en) && !$past(rd_data[3])));

  assert_tick_needs_core_R10: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> core_en);
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.BUS_W(BUS_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .wake_evt    (wake_evt),
  .rd_data     (rd_data),
  .core_en     (core_en),
  .core_clk_en (core_clk_en)
);

// File: tb/pwr_clk_ctrl_tb.sv
module pwr_clk_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [BUS_W-1:0] wr_data = '0;
  logic             wake_evt = 1'b0;
  logic [BUS_W-1:0] rd_data;
  logic core_en, periph_en, pll_en, xtal_en, prec_en, core_clk_en;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // reference state
  logic [7:0] m_reg = 8'h79;
  bit         m_run = 1'b1;
  int         m_cnt = 0;
  bit         m_tick = 1'b0;
  int         m_cd_seen = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_clk_ctrl #(.BUS_W(BUS_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wake_evt(wake_evt),
    .rd_data(rd_data), .core_en(core_en), .periph_en(periph_en), .pll_en(pll_en),
    .xtal_en(xtal_en), .prec_en(prec_en), .core_clk_en(core_clk_en)
  );

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_reg = 8'h79; m_run = 1; m_cnt = 0; m_tick = 0; m_cd_seen = 1;
    end else begin
      logic [7:0] req, nreg;
      bit keep_going;
      int code;
      nreg = m_reg;
      if (wr_en) begin
        req = wr_data[7:0];
        nreg = req;
        if (req[3] && !req[4]) nreg[4] = m_reg[4];              // R3
        if (!req[5] && (req[3] || req[4])) nreg[5] = m_reg[5];   // R4
      end
      if (wake_evt) nreg[5:3] = 3'b111;                          // R6
      keep_going = m_reg[3] || (m_run && !m_tick);               // R9
      code = int'(m_reg[2:0]);
      if (!keep_going || code != m_cd_seen) begin
        m_cnt = 0; m_tick = 0; m_cd_seen = code;
      end else if (m_cnt == (1 << code) - 1) begin
        m_cnt = 0; m_tick = 1;
      end else begin
        m_cnt++; m_tick = 0;
      end
      m_run = keep_going;
      m_reg = nreg;
    end
  end

  task automatic compare();
    logic [BUS_W-1:0] exp_rd;
    exp_rd = BUS_W'(m_reg);
    n_vec++;
    if (rd_data !== exp_rd || core_en !== m_run || core_clk_en !== m_tick ||
        periph_en !== m_reg[4] || pll_en !== m_reg[5] || xtal_en !== m_reg[6] ||
        prec_en !== m_reg[7]) begin
      n_bad++;
      $display("FAIL %s: rd=%h run=%b tick=%b en=%b%b%b%b expected rd=%h run=%b tick=%b",
               cur_req, rd_data, core_en, core_clk_en, prec_en, xtal_en, pll_en, periph_en,
               exp_rd, m_run, m_tick);
    end
  endtask

  task automatic step(input bit we, input logic [BUS_W-1:0] d, input bit wk);
    @(negedge clk);
    compare();
    wr_en = we; wr_data = d; wake_evt = wk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1"; idle(8);                       // reset state, code 1 pulses
    cur_req = "R7";
    for (int c = 0; c < 8; c++) begin
      step(1, BUS_W'(8'h78 | c), 0);
      idle((1 << c) * 3 + 2);
    end
    cur_req = "R8";
    step(1, BUS_W'(8'h7B), 0); idle(5);
    step(1, BUS_W'(8'h7A), 0); idle(2);
    step(1, BUS_W'(8'h7C), 0); idle(20);
    cur_req = "R3"; step(1, BUS_W'(8'h69), 0); idle(4);
    cur_req = "R5"; step(1, BUS_W'(8'hAA), 0); idle(6);
    cur_req = "R4"; step(1, BUS_W'(8'h5A), 0); idle(4);
    cur_req = "R9";                                 // core off, bit5 kept (R4)
    step(1, BUS_W'(8'h52), 0); idle(12);
    cur_req = "R10"; idle(10); step(0, '0, 1); idle(10);
    cur_req = "R9"; step(1, BUS_W'(8'h45), 0); idle(20);   // full down, slow code
    cur_req = "R6"; step(1, BUS_W'(8'h41), 1); idle(6);
    step(1, BUS_W'(8'h60), 0); idle(3);
    step(1, BUS_W'(8'h00), 1); idle(4);
    cur_req = "R10"; step(1, BUS_W'(8'h78), 0); idle(6);
    cur_req = "R11"; step(1, 32'hFFFF_FF79, 0); idle(3);
    step(1, 32'hA5A5_0071, 0); idle(6);
    step(0, '0, 1); idle(4);
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 30, BUS_W'($urandom), r > 94);
    end
    cur_req = "R1"; rst = 1'b1; idle(2); rst = 1'b0; idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule